// File: doc/BRIEF.md
# Rotate and Insert Selected Bits Unit

This unit is one stage of a 64-bit integer datapath. It rotates a source operand left by an immediate count, selects a contiguous run of bit positions (which may wrap around), and merges the selected rotated bits into an existing destination value. The remaining destination bits are either kept or cleared. The unit has three variants. One works over the whole 64-bit word. The other two confine the selection to the upper or the lower 32-bit half, and these two always leave the opposite half untouched.

Bit positions are counted big-endian: position 0 is bit 63 of the word and position 63 is bit 0. In the half variants, positions are counted from the top of the selected half. A caller presents all operands with a valid strobe and receives the merged word, together with a valid flag and an illegal-opcode flag, on the next clock.

Top module: `rot_ins_unit`

## Requirements
- R1: The opcode selects the variant: 0x55 is the full 64-bit variant, 0x5D is the high-half variant and 0x51 is the low-half variant. Any other opcode sets illegal_op together with out_valid, and result then equals the old destination unchanged.
- R2: In the full variant, let s be start_pos mod 64 and e be end_pos mod 64. When s <= e, positions s through e inclusive (position p is bit 63-p) take the rotated source, and every other position keeps the old destination.
- R3: When s > e, the selection wraps around. It covers positions s through the last position of the partition and also the first position of the partition through e.
- R4: In the half variants, s and e are taken mod 32 and count positions from the top of the chosen half: bits 63..32 for the high variant and bits 31..0 for the low variant. The selection never leaves that half.
- R5: Bit 7 of the raw end_pos is the zero flag. It is read before the modulo reduction. In the full variant with the flag set, every bit that is not selected is 0.
- R6: In the half variants with the zero flag set, the bits of the chosen half that are not selected are 0, and the opposite half always equals the old destination, whether or not the flag is set.
- R7: The source is rotated left by rot_amt mod 64 before selection. Bits 7:6 of rot_amt have no effect.
- R8: result, out_valid and illegal_op appear exactly one clock after in_valid. out_valid stays low when in_valid was low. A synchronous active-high reset clears out_valid and illegal_op.
- R9: Bits of start_pos and end_pos above the modulo width have no effect, apart from bit 7 of end_pos acting as the zero flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| opcode | input | 8 | Variant select |
| start_pos | input | 8 | First selected position |
| end_pos | input | 8 | Last selected position; bit 7 is the zero flag |
| rot_amt | input | 8 | Left rotate count |
| src | input | 64 | Source operand to rotate |
| dst_old | input | 64 | Old destination value |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Merged word |
| illegal_op | output | 1 | Opcode was not one of the three variants |

## Verification
The bench aims at the mask edges.

- **Single-bit selection (start equal to end).** An off-by-one in the end shift would insert two bits or none.
- **Wrapped selection (start past end).** A design that ignores wrap-around would produce an empty or inverted mask.
- **Rotate counts of 0 and 63, and counts with junk upper bits.** A bad rotate would expose a zero-fill shift or an unreduced count.
- **Zero flag in each variant, including with junk in the low bits of end_pos.** A half variant that cleared the whole word, or a reduction that dropped bit 7 too early, would corrupt the opposite half or fail to clear.
- **Illegal opcodes and random operands for every opcode.** These catch a wrong partition choice and a missing error flag.

// File: rtl/rot_ins_unit.sv
module rot_ins_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  opcode,
  input  logic [7:0]  start_pos,
  input  logic [7:0]  end_pos,
  input  logic [7:0]  rot_amt,
  input  logic [63:0] src,
  input  logic [63:0] dst_old,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        illegal_op
);
  localparam logic [7:0] OP_FULL = 8'h55;
  localparam logic [7:0] OP_HIGH = 8'h5D;
  localparam logic [7:0] OP_LOW  = 8'h51;

  logic        is_full, is_high, is_low, legal, zero_rest;
  logic [5:0]  s_pos, e_pos, r_cnt;
  logic [6:0]  e_next, r_back;
  logic [63:0] pmask, head, tail, sel_mask, keep_mask, rotated, merged;

  assign is_full   = (opcode == OP_FULL);
  assign is_high   = (opcode == OP_HIGH);
  assign is_low    = (opcode == OP_LOW);
  assign legal     = is_full | is_high | is_low;
  assign zero_rest = end_pos[7];

  assign s_pos  = is_full ? start_pos[5:0] : {1'b0, start_pos[4:0]};
  assign e_pos  = is_full ? end_pos[5:0]   : {1'b0, end_pos[4:0]};
  assign e_next = {1'b0, e_pos} + 7'd1;

  assign pmask = is_high ? {{32{1'b1}}, 32'h0} :
                 is_low  ? {32'h0, {32{1'b1}}} : {64{1'b1}};

  assign head = pmask >> s_pos;
  assign tail = pmask >> e_next;

  assign sel_mask  = ((s_pos <= e_pos) ? (head ^ tail) : (head | ~tail)) & pmask;
  assign keep_mask = zero_rest ? (is_full ? 64'h0 : ~pmask) : ~sel_mask;

  assign r_cnt   = rot_amt[5:0];
  assign r_back  = 7'd64 - {1'b0, r_cnt};
  assign rotated = (src << r_cnt) | (src >> r_back);

  assign merged = legal ? ((rotated & sel_mask) | (dst_old & keep_mask)) : dst_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      illegal_op <= 1'b0;
      result     <= 64'h0;
    end else begin
      out_valid  <= in_valid;
      illegal_op <= in_valid & ~legal;
      if (in_valid) result <= merged;
    end
  end

  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_illegal_flag_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode != OP_FULL && opcode != OP_HIGH && opcode != OP_LOW)
      |=> (illegal_op && result == $past(dst_old)));
  assert_flag_gated_R1: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !illegal_op);
  assert_high_keeps_low_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OP_HIGH) |=> (result[31:0] == $past(dst_old[31:0])));
  assert_low_keeps_high_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OP_LOW) |=> (result[63:32] == $past(dst_old[63:32])));
  assert_mask_in_part_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ((sel_mask & ~pmask) == 64'h0));
  assert_full_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OP_FULL && end_pos[7])
      |=> ((result & ~$past(sel_mask)) == 64'h0));
endmodule

// File: tb/rot_ins_unit_tb.sv
module rot_ins_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [7:0]  opcode, start_pos, end_pos, rot_amt;
  logic [63:0] src, dst_old;
  logic        out_valid, illegal_op;
  logic [63:0] result;

  always #10 clk = ~clk;

  rot_ins_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .start_pos(start_pos), .end_pos(end_pos), .rot_amt(rot_amt),
    .src(src), .dst_old(dst_old), .out_valid(out_valid),
    .result(result), .illegal_op(illegal_op));

  typedef struct {
    logic [63:0] res;
    logic        err;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;
  int   cycles  = 0;

  function automatic exp_t model(input logic [7:0] op, input logic [7:0] st,
                                 input logic [7:0] en, input logic [7:0] ro,
                                 input logic [63:0] s, input logic [63:0] d);
    exp_t x;
    int base, width, sv, ev, r;
    bit zero, sel;
    x.err = 0;
    x.res = d;
    if (op == 8'h55) begin base = 0;  width = 64; end
    else if (op == 8'h5D) begin base = 0;  width = 32; end
    else if (op == 8'h51) begin base = 32; width = 32; end
    else begin x.err = 1; return x; end
    sv = st % width;
    ev = en % width;
    zero = en[7];
    r = ro % 64;
    for (int p = 0; p < 64; p++) begin
      int bi, q;
      bi = 63 - p;
      q = p - base;
      if (q < 0 || q >= width) continue;
      sel = (sv <= ev) ? (q >= sv && q <= ev) : (q >= sv || q <= ev);
      if (sel) x.res[bi] = s[(bi - r + 64) % 64];
      else if (zero) x.res[bi] = 1'b0;
    end
    return x;
  endfunction

  task automatic drive(input logic [7:0] op, input logic [7:0] st,
                       input logic [7:0] en, input logic [7:0] ro,
                       input logic [63:0] s, input logic [63:0] d,
                       input string tag);
    exp_t x;
    @(negedge clk);
    in_valid = 1; opcode = op; start_pos = st; end_pos = en; rot_amt = ro;
    src = s; dst_old = d;
    x = model(op, st, en, ro, s, d);
    x.tag = tag;
    exp_q.push_back(x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done && out_valid) begin
      exp_t x;
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R8: out_valid without request, actual=1 expected=0");
      end else begin
        x = exp_q.pop_front();
        if (result !== x.res || illegal_op !== x.err) begin
          n_fail++;
          $display("FAIL %s: actual=%h/%b expected=%h/%b", x.tag, result,
                   illegal_op, x.res, x.err);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [63:0] a, b;
    logic [7:0] ops[3];
    ops[0] = 8'h55; ops[1] = 8'h5D; ops[2] = 8'h51;
    rst = 1; in_valid = 0; opcode = 0; start_pos = 0; end_pos = 0; rot_amt = 0;
    src = 0; dst_old = 0;
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0 || illegal_op !== 1'b0) begin
      n_fail++;
      $display("FAIL R8 reset: actual=%b%b expected=00", out_valid, illegal_op);
    end
    rst = 0;
    a = 64'h0123_4567_89AB_CDEF;
    b = 64'hFEDC_BA98_7654_3210;
    // R2 plain range, start equal to end
    drive(8'h55, 8'd8, 8'd15, 8'd0, a, b, "R2 range");
    drive(8'h55, 8'd5, 8'd5, 8'd0, {64{1'b1}}, 64'h0, "R2 single bit");
    drive(8'h55, 8'd0, 8'd63, 8'd0, a, b, "R2 whole word");
    // R3 wrap
    drive(8'h55, 8'd60, 8'd3, 8'd0, {64{1'b1}}, 64'h0, "R3 wrap full");
    drive(8'h5D, 8'd30, 8'd1, 8'd0, {64{1'b1}}, 64'h0, "R3 wrap high");
    drive(8'h51, 8'd31, 8'd0, 8'd0, {64{1'b1}}, 64'h0, "R3 wrap low");
    // R4 half variants
    drive(8'h5D, 8'd0, 8'd31, 8'd0, a, b, "R4 high half");
    drive(8'h51, 8'd0, 8'd31, 8'd0, a, b, "R4 low half");
    drive(8'h51, 8'd4, 8'd9, 8'd12, a, b, "R4 low range");
    // R5 and R6 zero flag
    drive(8'h55, 8'd10, 8'h80 | 8'd20, 8'd3, a, b, "R5 zero full");
    drive(8'h55, 8'd50, 8'h80 | 8'd2, 8'd3, a, b, "R5 zero full wrap");
    drive(8'h5D, 8'd3, 8'h80 | 8'd7, 8'd0, a, {64{1'b1}}, "R6 zero high");
    drive(8'h51, 8'd3, 8'h80 | 8'd7, 8'd0, a, {64{1'b1}}, "R6 zero low");
    drive(8'h51, 8'd3, 8'hE0 | 8'd7, 8'd0, a, {64{1'b1}}, "R6 zero low junk");
    // R7 rotate
    drive(8'h55, 8'd0, 8'd63, 8'd63, a, b, "R7 rot 63");
    drive(8'h55, 8'd0, 8'd63, 8'd1, 64'h8000_0000_0000_0001, 0, "R7 rot 1");
    drive(8'h55, 8'd0, 8'd63, 8'hC1, a, b, "R7 rot upper ignored");
    // R9 upper bits of start and end
    drive(8'h55, 8'h48, 8'h4F, 8'd0, a, b, "R9 full upper bits");
    drive(8'h5D, 8'h64, 8'h6A, 8'd5, a, b, "R9 half upper bits");
    // R1 illegal opcodes
    drive(8'h00, 8'd1, 8'd2, 8'd3, a, b, "R1 illegal 00");
    drive(8'h56, 8'd1, 8'h82, 8'd3, a, b, "R1 illegal 56");
    drive(8'h55, 8'd1, 8'd2, 8'd3, a, b, "R1 legal after illegal");
    // R8 gaps
    idle(3);
    drive(8'h5D, 8'd2, 8'd9, 8'd17, b, a, "R8 after gap");
    idle(2);
    // random over all opcodes
    for (int i = 0; i < 900; i++) begin
      drive(ops[i % 3], 8'($urandom), 8'($urandom), 8'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom}, "R2 R3 R4 R7 random");
      if ((i % 17) == 0) idle(1);
    end
    idle(4);
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R8: pending results actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule